// File: doc/BRIEF.md
# Coprocessor Exception Entry Unit

This unit holds the system-control state of a small 32-bit MIPS-I-style core: the status word, the cause word, the saved exception PC and a fixed processor identifier. A synchronous exception request comes with a 5-bit code and a delay-slot flag. Whenever such a request arrives, or an enabled hardware interrupt is pending, the unit does the whole entry in one clock. It records the cause, saves the return address, pushes the mode/enable stack in the status word, and issues a redirect to the handler vector.

The pipeline presents the PC of the instruction that is current. It may also pulse a return-from-exception strobe, which pops the status stack, or load a new status word through the move-to-coprocessor path. The interrupt source is a pending word and a mask word. An interrupt is taken only when the two overlap, the hardware-interrupt mask bit is set and the global enable bit is set. All outputs are registered.

Top module: `exc_entry_unit`

## Requirements
- R1: While reset is held, and after it is released with no event, the outputs are: PC 0xBFC00000, status 0x10900000, identifier 0x00000002, cause 0, saved PC 0, redirect 0.
- R2: On a synchronous entry, cause bits 9:8 keep their old value, bits 6:2 take the 5-bit code, bit 31 takes the delay-slot flag, and every other bit becomes 0.
- R3: On a synchronous entry, the saved PC is the current PC minus 4 when the delay-slot flag is set, and the current PC otherwise.
- R4: On any entry, the next PC is 0xBFC00180 if status bit 22 was set, and 0x80000080 if it was clear.
- R5: On any entry, status bits 5:0 become the old bits 3:0 shifted left by two, and bits 31:6 are unchanged.
- R6: An interrupt entry occurs only when (pending AND mask) is nonzero, status bit 10 is 1 and status bit 0 is 1. Otherwise the inputs change nothing.
- R7: An interrupt entry sets cause to (old bits 9:8) OR 0x400, with bit 31 clear, and saves the current PC unchanged, whatever the delay-slot flag is.
- R8: Without an entry, the return strobe copies status bits 5:2 into bits 3:0 and leaves bits 31:4 unchanged.
- R9: A synchronous request beats a simultaneous interrupt. The interrupt condition is evaluated again on every later cycle against the status word current in that cycle.
- R10: A status load is applied only in a cycle with no entry and no return strobe.
- R11: Redirect is 1 for exactly the cycle after each entry, and the PC output changes only on an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 5 | Exception code for cause bits 6:2 |
| exc_in_delay | input | 1 | Faulting instruction is in a branch delay slot |
| cur_pc | input | 32 | PC of the current instruction |
| irq_pend | input | IRQ_W | Pending interrupt lines |
| irq_mask | input | IRQ_W | Interrupt mask lines |
| rfe_stb | input | 1 | Return-from-exception strobe |
| st_load | input | 1 | Load the status word |
| st_load_val | input | 32 | Value for a status load |
| pc_out | output | 32 | Redirect target / reset PC |
| pc_redirect | output | 1 | PC output was just updated by an entry |
| status_out | output | 32 | Status word |
| cause_out | output | 32 | Cause word |
| epc_out | output | 32 | Saved exception PC |
| prid_out | output | 32 | Processor identifier |

## Verification
Every piece of state here is visible at a port, so a corrupted status stack or cause word shows up one clock after the event that caused it. The effect then carries into later cycles. A wrong enable bit either starts a spurious interrupt entry, with a redirect and a new saved PC, on the very next cycle, or keeps a real one from happening. A wrong stack shift shows up again when a later return strobe restores the wrong mode bits. The bench therefore chains entries, returns and loads so that each cycle's expected word depends on the earlier results.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN   = 32;
  localparam int CODE_W = 5;

  // status bit positions the entry logic decodes
  localparam int ST_IE_CUR = 0;
  localparam int ST_IM_HW  = 10;
  localparam int ST_BEV    = 22;

  localparam logic [XLEN-1:0] CAUSE_KEEP_MASK = 32'h0000_0300;
  localparam logic [XLEN-1:0] CAUSE_IRQ_WORD  = 32'h0000_0400;

  typedef enum logic [1:0] {
    ENT_NONE = 2'd0,
    ENT_SYNC = 2'd1,
    ENT_IRQ  = 2'd2
  } entry_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int IRQ_W = 8
) (
  input  logic             exc_req,
  input  logic [IRQ_W-1:0] irq_pend,
  input  logic [IRQ_W-1:0] irq_mask,
  input  logic             st_ie,
  input  logic             st_im,
  output entry_e           kind
);
  logic irq_hit;

  always_comb begin
    irq_hit = (|(irq_pend & irq_mask)) && st_ie && st_im;
    if (exc_req)      kind = ENT_SYNC;
    else if (irq_hit) kind = ENT_IRQ;
    else              kind = ENT_NONE;
  end
endmodule

// File: rtl/exc_status_reg.sv
module exc_status_reg
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] RST_VAL = 32'h1090_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enter,
  input  logic            rfe,
  input  logic            load,
  input  logic [XLEN-1:0] load_val,
  output logic [XLEN-1:0] status
);
  always_ff @(posedge clk) begin
    if (rst)         status <= RST_VAL;
    else if (enter)  status <= {status[XLEN-1:6], status[3:0], 2'b00};
    else if (rfe)    status <= {status[XLEN-1:6], status[5:4], status[5:2]};
    else if (load)   status <= load_val;
  end

  p_stack_push_r5: assert property (@(posedge clk) disable iff (rst)
    enter |=> (status[5:0] == {$past(status[3:0]), 2'b00}) &&
              (status[XLEN-1:6] == $past(status[XLEN-1:6])));

  p_stack_pop_r8: assert property (@(posedge clk) disable iff (rst)
    (rfe && !enter) |=> (status[XLEN-1:4] == $past(status[XLEN-1:4])) &&
                        (status[3:0] == $past(status[5:2])));

  p_load_gated_r10: assert property (@(posedge clk) disable iff (rst)
    (!enter && !rfe && !load) |=> $stable(status));
endmodule

// File: rtl/exc_cause_epc.sv
module exc_cause_epc
  import exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  entry_e            kind,
  input  logic [CODE_W-1:0] code,
  input  logic              in_delay,
  input  logic [XLEN-1:0]   cur_pc,
  output logic [XLEN-1:0]   cause,
  output logic [XLEN-1:0]   epc
);
  logic [XLEN-1:0] cause_nxt;
  logic [XLEN-1:0] epc_nxt;

  always_comb begin
    cause_nxt = cause & CAUSE_KEEP_MASK;
    epc_nxt   = cur_pc;
    if (kind == ENT_SYNC) begin
      cause_nxt[CODE_W+1:2] = code;
      cause_nxt[XLEN-1]     = in_delay;
      if (in_delay) epc_nxt = cur_pc - 32'd4;
    end else begin
      cause_nxt = cause_nxt | CAUSE_IRQ_WORD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause <= '0;
      epc   <= '0;
    end else if (kind != ENT_NONE) begin
      cause <= cause_nxt;
      epc   <= epc_nxt;
    end
  end

  p_keep_ip_r2: assert property (@(posedge clk) disable iff (rst)
    (kind != ENT_NONE) |=> cause[9:8] == $past(cause[9:8]));

  p_irq_word_r7: assert property (@(posedge clk) disable iff (rst)
    (kind == ENT_IRQ) |=> (cause[XLEN-1] == 1'b0) && cause[10] &&
                          (epc == $past(cur_pc)));

  p_sync_code_r2: assert property (@(posedge clk) disable iff (rst)
    (kind == ENT_SYNC) |=> (cause[CODE_W+1:2] == $past(code)) &&
                           (cause[XLEN-1] == $past(in_delay)));
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int              IRQ_W      = 8,
  parameter logic [XLEN-1:0] RESET_PC   = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] RESET_ST   = 32'h1090_0000,
  parameter logic [XLEN-1:0] PRID_VAL   = 32'h0000_0002,
  parameter logic [XLEN-1:0] VEC_BOOT   = 32'hBFC0_0180,
  parameter logic [XLEN-1:0] VEC_NORMAL = 32'h8000_0080
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              exc_in_delay,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [IRQ_W-1:0]  irq_pend,
  input  logic [IRQ_W-1:0]  irq_mask,
  input  logic              rfe_stb,
  input  logic              st_load,
  input  logic [XLEN-1:0]   st_load_val,
  output logic [XLEN-1:0]   pc_out,
  output logic              pc_redirect,
  output logic [XLEN-1:0]   status_out,
  output logic [XLEN-1:0]   cause_out,
  output logic [XLEN-1:0]   epc_out,
  output logic [XLEN-1:0]   prid_out
);
  entry_e kind;
  logic   enter;
  logic [XLEN-1:0] status_q;

  exc_arbiter #(.IRQ_W(IRQ_W)) arb_i (
    .exc_req (exc_req),
    .irq_pend(irq_pend),
    .irq_mask(irq_mask),
    .st_ie   (status_q[ST_IE_CUR]),
    .st_im   (status_q[ST_IM_HW]),
    .kind    (kind)
  );

  assign enter = (kind != ENT_NONE);

  exc_status_reg #(.RST_VAL(RESET_ST)) st_i (
    .clk     (clk),
    .rst     (rst),
    .enter   (enter),
    .rfe     (rfe_stb),
    .load    (st_load),
    .load_val(st_load_val),
    .status  (status_q)
  );

  exc_cause_epc ce_i (
    .clk     (clk),
    .rst     (rst),
    .kind    (kind),
    .code    (exc_code),
    .in_delay(exc_in_delay),
    .cur_pc  (cur_pc),
    .cause   (cause_out),
    .epc     (epc_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_out      <= RESET_PC;
      pc_redirect <= 1'b0;
      prid_out    <= PRID_VAL;
    end else begin
      pc_redirect <= enter;
      if (enter) pc_out <= status_q[ST_BEV] ? VEC_BOOT : VEC_NORMAL;
    end
  end

  assign status_out = status_q;

  p_vector_r4: assert property (@(posedge clk) disable iff (rst)
    enter |=> pc_out == ($past(status_q[ST_BEV]) ? VEC_BOOT : VEC_NORMAL));

  p_epc_delay_r3: assert property (@(posedge clk) disable iff (rst)
    (kind == ENT_SYNC) |=> epc_out == ($past(exc_in_delay) ? $past(cur_pc) - 32'd4
                                                           : $past(cur_pc)));

  p_sync_first_r9: assert property (@(posedge clk) disable iff (rst)
    (exc_req && |(irq_pend & irq_mask)) |=> cause_out[10] == 1'b0 || !pc_redirect);

  p_pc_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !enter |=> !pc_redirect && $stable(pc_out));

  p_irq_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (!exc_req && !(status_q[ST_IE_CUR] && status_q[ST_IM_HW])) |=> !pc_redirect);
endmodule

// File: tb/exc_entry_unit_tb_top.sv
module exc_entry_unit_tb_top;
  localparam int IRQ_W = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exc_req = 1'b0;
  logic [4:0]  exc_code = '0;
  logic        exc_in_delay = 1'b0;
  logic [31:0] cur_pc = '0;
  logic [IRQ_W-1:0] irq_pend = '0;
  logic [IRQ_W-1:0] irq_mask = '0;
  logic        rfe_stb = 1'b0;
  logic        st_load = 1'b0;
  logic [31:0] st_load_val = '0;
  logic [31:0] pc_out, status_out, cause_out, epc_out, prid_out;
  logic        pc_redirect;

  exc_entry_unit #(.IRQ_W(IRQ_W)) dut_i (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_code(exc_code),
    .exc_in_delay(exc_in_delay), .cur_pc(cur_pc), .irq_pend(irq_pend),
    .irq_mask(irq_mask), .rfe_stb(rfe_stb), .st_load(st_load),
    .st_load_val(st_load_val), .pc_out(pc_out), .pc_redirect(pc_redirect),
    .status_out(status_out), .cause_out(cause_out), .epc_out(epc_out),
    .prid_out(prid_out)
  );

  always #5 clk = ~clk;

  typedef struct {
    int          due;
    string       tag;
    logic [31:0] pc, st, cause, epc;
    logic        redir;
  } exp_t;

  exp_t exp_q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_pc = 32'hBFC0_0000;
  logic [31:0] m_st = 32'h1090_0000;
  logic [31:0] m_cause = '0;
  logic [31:0] m_epc = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push the expected outcome
  task automatic step(bit ex, logic [4:0] code, bit dly, logic [31:0] pc,
                      logic [7:0] pend, logic [7:0] mask, bit rfe, bit ld,
                      logic [31:0] ldv, string tag);
    exp_t e;
    bit sync_e, irq_e;
    @(negedge clk);
    exc_req = ex; exc_code = code; exc_in_delay = dly; cur_pc = pc;
    irq_pend = pend; irq_mask = mask; rfe_stb = rfe; st_load = ld; st_load_val = ldv;
    sync_e = ex;
    irq_e  = !ex && ((pend & mask) != 0) && m_st[10] && m_st[0];
    e.redir = sync_e || irq_e;
    if (sync_e || irq_e) begin
      m_pc = m_st[22] ? 32'hBFC0_0180 : 32'h8000_0080;
      if (sync_e) begin
        m_cause = (m_cause & 32'h300) | ({27'd0, code} << 2) | ({31'd0, dly} << 31);
        m_epc   = dly ? pc - 32'd4 : pc;
      end else begin
        m_cause = (m_cause & 32'h300) | 32'h400;
        m_epc   = pc;
      end
      m_st = {m_st[31:6], m_st[3:0], 2'b00};
    end else if (rfe) begin
      m_st = {m_st[31:4], m_st[5:2]};
    end else if (ld) begin
      m_st = ldv;
    end
    e.due = cyc + 1; e.tag = tag;
    e.pc = m_pc; e.st = m_st; e.cause = m_cause; e.epc = m_epc;
    exp_q.push_back(e);
  endtask

  // monitor: compare outputs on the falling edge when an item is due
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        cmp(e.tag, "pc", pc_out, e.pc);
        cmp(e.tag, "status", status_out, e.st);
        cmp(e.tag, "cause", cause_out, e.cause);
        cmp(e.tag, "epc", epc_out, e.epc);
        cmp(e.tag, "redirect", {31'd0, pc_redirect}, {31'd0, e.redir});
        cmp(e.tag, "prid", prid_out, 32'h2);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values while reset is held
    cmp("R1", "pc", pc_out, 32'hBFC0_0000);
    cmp("R1", "status", status_out, 32'h1090_0000);
    cmp("R1", "prid", prid_out, 32'h2);
    rst = 1'b0;
    step(0, 0, 0, 32'h0, 0, 0, 0, 0, 0, "R1");
    step(1, 5'd4, 0, 32'h100, 0, 0, 0, 0, 0, "R2");        // R4 normal vector
    step(0, 0, 0, 0, 0, 0, 0, 1, 32'h0040_0405, "R10");
    step(1, 5'd8, 1, 32'h2004, 0, 0, 0, 0, 0, "R3");       // R4 boot vector, R5
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, "R8");
    step(0, 0, 1, 32'h3000, 8'h01, 8'h01, 0, 0, 0, "R7");
    step(0, 0, 0, 32'h3004, 8'h01, 8'h01, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, "R8");
    step(1, 5'd12, 1, 32'h4008, 8'h01, 8'h01, 0, 0, 0, "R9");
    step(0, 0, 0, 32'h5000, 8'h01, 8'h01, 1, 0, 0, "R9");
    step(0, 0, 0, 32'h5004, 8'h01, 8'h01, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, "R8");
    step(0, 0, 0, 32'h6000, 8'hF0, 8'h0F, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_0001, "R10");
    step(0, 0, 0, 32'h6004, 8'hFF, 8'hFF, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 1, 1, 32'h0000_0005, "R10");
    step(1, 5'd31, 0, 32'h10, 0, 0, 0, 0, 0, "R4");
    step(1, 5'd1, 0, 32'h20, 0, 0, 0, 1, 32'hFFFF_FFFF, "R10");
    step(0, 0, 0, 32'h30, 0, 0, 0, 0, 0, "R11");
    step(0, 0, 0, 32'h34, 0, 0, 0, 0, 0, "R11");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule